// File: doc/BRIEF.md
# Priority Interrupt Controller

An eight-line priority interrupt controller with a byte-wide register interface at two addresses. The control address takes the start-of-configuration word, the end-of-interrupt command and the read-select command. Reads from it return either the pending-request bits or the in-service bits. The auxiliary address takes the rest of the configuration sequence. Once configuration is complete, it loads the mask register.

Each input line is edge or level sensitive. A per-line trigger register, written through its own strobe, makes that choice. A global level bit in the first configuration word can also force every line to level mode. The highest-priority unmasked request raises the processor interrupt output when it outranks everything already in service. An acknowledge strobe moves that request into service and presents an 8-bit vector: the programmed base plus the line number. The third configuration word is kept as the cascade setting. On a master it is the mask of lines with slaves attached. On a slave it is the slave's own identity.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is 0xFF (all lines disabled), the interrupt output is low, the in-service and request bits are zero, and control-address reads return the request bits.
- R2: A control-address write with bit 4 set starts configuration. The next three auxiliary writes load the vector base, then the cascade word, then the mode word; the mode word is expected only if bit 0 of the start word was set. These writes leave the mask unchanged. The first auxiliary write after the sequence loads the mask.
- R3: The cascade output shows the last cascade word written. During an acknowledge, the vector output equals the base plus the index of the winning line (modulo 256). Outside an acknowledge it reads zero.
- R4: Auxiliary-address reads always return the mask. A mask bit of 1 keeps its line from raising the interrupt or being acknowledged.
- R5: An edge-mode line latches a request when it is sampled high after having been sampled low. The latch stays set until that line is acknowledged. The line must go low and high again before it can request again.
- R6: A line is in level mode when its trigger bit is 1, or when bit 3 of the start word was set. In level mode it requests exactly while its input is high, with no clock delay.
- R7: Line 0 has the highest priority. The interrupt output is high only when an unmasked request exists whose line index is lower than every in-service bit.
- R8: An acknowledge with an unmasked request pending sets the winner's in-service bit and clears its edge latch.
- R9: A control write with bits 4:3 = 00 and bits 7:5 = 001 clears the lowest-index set in-service bit. Any other value with bits 4:3 = 00 has no effect.
- R10: A control write with bits 4:3 = 01 and bit 1 set selects what control reads return: in-service bits if bit 0 = 1, request bits if bit 0 = 0. A start word resets the selection to request bits.
- R11: An acknowledge with no unmasked request returns the base plus 7 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control address, 1 = auxiliary address |
| wr_data | input | 8 | Write data |
| trig_we | input | 1 | Loads the trigger register from wr_data |
| rd_data | output | 8 | Read data for the selected address (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| inta | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector during acknowledge, zero otherwise |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
The hardest state to reach is nested service. A higher-priority line must arrive while a lower one is already in service. Then a lower one must stay pending behind it. End-of-interrupt commands must then unwind the in-service bits one at a time. The stimulus builds this by acknowledging line 3, raising lines 1 and 5 together, and issuing two end-of-interrupts, with the read-select command used between steps to expose the in-service bits. A second configuration pass with the global level bit set shows how start words reshape port meaning and read selection.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);
    localparam int DW    = 8;

    typedef enum logic [1:0] {
        INIT_IDLE,
        INIT_BASE,
        INIT_CASC,
        INIT_MODE
    } init_state_e;

    typedef struct packed {
        logic start;
        logic cmd_eoi;
        logic cmd_rdsel;
        logic aux_load;
    } wr_decode_t;

    function automatic logic [LINES-1:0] lowest_onehot(input logic [LINES-1:0] v);
        return v & (~v + 1'b1);
    endfunction

    function automatic logic [IDX_W-1:0] onehot_to_idx(input logic [LINES-1:0] oh);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < LINES; i++)
            if (oh[i]) r = r | IDX_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/pic_regif.sv
module pic_regif
    import pic_pkg::*;
#(
    parameter int N = LINES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wr_data,
    output logic [N-1:0]  mask,
    output logic [DW-1:0] base,
    output logic [DW-1:0] casc,
    output logic          ltim,
    output logic          sel_isr,
    output logic          eoi
);
    init_state_e state;
    logic        need_mode;
    wr_decode_t  dec;

    always_comb begin
        dec.start     = wr_en && !addr && wr_data[4];
        dec.cmd_eoi   = wr_en && !addr && (wr_data[4:3] == 2'b00) && (wr_data[7:5] == 3'b001);
        dec.cmd_rdsel = wr_en && !addr && (wr_data[4:3] == 2'b01) && wr_data[1];
        dec.aux_load  = wr_en && addr;
    end

    assign eoi = dec.cmd_eoi;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= INIT_IDLE;
            need_mode <= 1'b0;
            mask      <= '1;
            base      <= '0;
            casc      <= '0;
            ltim      <= 1'b0;
            sel_isr   <= 1'b0;
        end else if (dec.start) begin
            state     <= INIT_BASE;
            need_mode <= wr_data[0];
            ltim      <= wr_data[3];
            sel_isr   <= 1'b0;
        end else begin
            if (dec.cmd_rdsel) sel_isr <= wr_data[0];
            if (dec.aux_load) begin
                case (state)
                    INIT_IDLE: mask <= wr_data[N-1:0];
                    INIT_BASE: begin
                        base  <= wr_data;
                        state <= INIT_CASC;
                    end
                    INIT_CASC: begin
                        casc  <= wr_data;
                        state <= need_mode ? INIT_MODE : INIT_IDLE;
                    end
                    default:   state <= INIT_IDLE;
                endcase
            end
        end
    end

    AST_INIT_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dec.aux_load && state != INIT_IDLE) |=> $stable(mask)); // R2
    AST_START_SELECTS_IRR: assert property (@(posedge clk) disable iff (rst)
        dec.start |=> !sel_isr); // R10
endmodule

// File: rtl/pic_req.sv
module pic_req
    import pic_pkg::*;
#(
    parameter int N = LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] level_sel,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q;
    logic [N-1:0] latch_q;
    logic [N-1:0] rise;

    assign rise = lines & ~prev_q;
    assign irr  = (level_sel & lines) | (~level_sel & latch_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= lines;
            latch_q <= (latch_q & ~ack_clr) | rise;
        end
    end

    AST_EDGE_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        ((ack_clr & ~rise) != '0) |=> ((latch_q & $past(ack_clr & ~rise)) == '0)); // R5
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
    import pic_pkg::*;
#(
    parameter int N = LINES
) (
    input  logic [N-1:0] irr,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] isr,
    output logic [N-1:0] pend,
    output logic [N-1:0] win_oh,
    output logic         int_out
);
    logic [N-1:0] isr_top;

    always_comb begin
        pend    = irr & ~mask;
        win_oh  = lowest_onehot(pend);
        isr_top = lowest_onehot(isr);
        // both are one-hot, so a smaller value means a lower line index
        int_out = (pend != '0) && ((isr == '0) || (win_oh < isr_top));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         addr,
    input  logic [7:0]   wr_data,
    input  logic         trig_we,
    output logic [7:0]   rd_data,
    input  logic [7:0]   irq_in,
    input  logic         inta,
    output logic         int_out,
    output logic [7:0]   vec_out,
    output logic [7:0]   cascade_cfg
);
    localparam int N = LINES;

    logic [N-1:0]  mask, trig_q, level_sel, irr, pend, win_oh, isr_q;
    logic [N-1:0]  ack_oh, eoi_clr;
    logic [DW-1:0] base;
    logic          ltim, sel_isr, eoi, ack_take;
    logic [IDX_W-1:0] vec_idx;

    pic_regif #(.N(N)) regif_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .mask(mask), .base(base), .casc(cascade_cfg), .ltim(ltim),
        .sel_isr(sel_isr), .eoi(eoi)
    );

    assign level_sel = trig_q | {N{ltim}};

    pic_req #(.N(N)) req_i (
        .clk(clk), .rst(rst), .lines(irq_in), .level_sel(level_sel),
        .ack_clr(ack_oh), .irr(irr)
    );

    pic_resolve #(.N(N)) res_i (
        .irr(irr), .mask(mask), .isr(isr_q),
        .pend(pend), .win_oh(win_oh), .int_out(int_out)
    );

    assign ack_take = inta && (pend != '0);
    assign ack_oh   = ack_take ? win_oh : '0;
    assign eoi_clr  = eoi ? lowest_onehot(isr_q) : '0;
    assign vec_idx  = (pend != '0) ? onehot_to_idx(win_oh) : IDX_W'(N - 1);
    assign vec_out  = inta ? (base + {{(DW-IDX_W){1'b0}}, vec_idx}) : '0;
    assign rd_data  = addr ? mask : (sel_isr ? isr_q : irr);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            isr_q  <= '0;
        end else begin
            if (trig_we) trig_q <= wr_data[N-1:0];
            isr_q <= (isr_q & ~eoi_clr) | ack_oh;
        end
    end

    AST_INT_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (pend != '0)); // R7
    AST_ACK_ENTERS_ISR: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> ((isr_q & $past(win_oh)) != '0)); // R8
    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi && isr_q != '0 && !inta) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R9
    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (inta && pend == '0 && !eoi) |=> $stable(isr_q)); // R11
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, addr = 1'b0, trig_we = 1'b0, inta = 1'b0;
    logic [7:0] wr_data = '0, irq_in = '0;
    logic [7:0] rd_data, vec_out, cascade_cfg;
    logic       int_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .trig_we(trig_we), .rd_data(rd_data), .irq_in(irq_in), .inta(inta),
        .int_out(int_out), .vec_out(vec_out), .cascade_cfg(cascade_cfg)
    );

    // behavioural reference state
    bit [7:0] m_mask = 8'hFF, m_isr = 0, m_latch = 0, m_prev = 0, m_trig = 0;
    bit [7:0] m_base = 0, m_casc = 0;
    int       m_st = 0;
    bit       m_need4 = 0, m_ltim = 0, m_sel = 0;

    function automatic int low(bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit [7:0] m_irr();
        bit [7:0] lvl;
        lvl = m_trig | {8{m_ltim}};
        return (lvl & irq_in) | (~lvl & m_latch);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against model, clock once, advance model
    task automatic cyc();
        bit [7:0] pend, ackoh, eoiclr, e_rd, e_vec;
        int w;
        bit e_int;
        #1;
        pend  = m_irr() & ~m_mask;
        w     = low(pend);
        e_int = (pend != 0) && (w < low(m_isr));
        e_rd  = addr ? m_mask : (m_sel ? m_isr : m_irr());
        e_vec = inta ? 8'(m_base + ((pend != 0) ? w : 7)) : 8'h00;
        chk("R7 int_out", int_out, e_int);
        chk("R4 rd_data", rd_data, e_rd);
        chk("R3 vec_out", vec_out, e_vec);
        chk("R2 cascade", cascade_cfg, m_casc);
        @(posedge clk);
        ackoh  = (inta && pend != 0) ? 8'(1 << w) : 8'h00;
        eoiclr = 0;
        if (wr_en && !addr && wr_data[4:3] == 0 && wr_data[7:5] == 1 && low(m_isr) < 8)
            eoiclr = 8'(1 << low(m_isr));
        m_isr   = (m_isr & ~eoiclr) | ackoh;
        m_latch = (m_latch & ~ackoh) | (irq_in & ~m_prev);
        m_prev  = irq_in;
        if (trig_we) m_trig = wr_data;
        if (wr_en && !addr && wr_data[4]) begin
            m_st = 1; m_need4 = wr_data[0]; m_ltim = wr_data[3]; m_sel = 0;
        end else begin
            if (wr_en && !addr && wr_data[4:3] == 2'b01 && wr_data[1]) m_sel = wr_data[0];
            if (wr_en && addr) begin
                case (m_st)
                    0: m_mask = wr_data;
                    1: begin m_base = wr_data; m_st = 2; end
                    2: begin m_casc = wr_data; m_st = m_need4 ? 3 : 0; end
                    default: m_st = 0;
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(bit a, bit [7:0] d);
        wr_en = 1; addr = a; wr_data = d;
        cyc();
        wr_en = 0; addr = 0;
    endtask

    task automatic ack(int exp_vec, string tag);
        inta = 1;
        #1 chk(tag, vec_out, exp_vec);
        cyc();
        inta = 0;
    endtask

    task automatic peek_ctl(int exp, string tag);
        addr = 0;
        #1 chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        #1 chk("R1 int_out", int_out, 0);
        addr = 1;
        #1 chk("R1 mask", rd_data, 8'hFF);
        peek_ctl(0, "R1 irr");
        cyc();

        // R2 configuration with mode word
        wr(0, 8'h11);
        wr(1, 8'h40);
        addr = 1; #1 chk("R2 mask held", rd_data, 8'hFF);
        wr(1, 8'h04);
        chk("R3 cascade", cascade_cfg, 8'h04);
        wr(1, 8'h01);
        addr = 1; #1 chk("R2 mask held", rd_data, 8'hFF);
        wr(1, 8'h00);
        addr = 1; #1 chk("R4 mask loaded", rd_data, 8'h00);
        addr = 0;

        // R5 edge request on line 3
        irq_in = 8'h08;
        #1 chk("R5 not yet latched", int_out, 0);
        cyc();
        chk("R5 latched", int_out, 1);
        ack(8'h43, "R8 vector line 3");
        chk("R5 consumed", int_out, 0);
        peek_ctl(0, "R5 irr cleared");
        cyc(); cyc();

        // R7 nesting: line 1 preempts, line 5 waits
        irq_in = 8'h2A;
        cyc();
        chk("R7 higher preempts", int_out, 1);
        ack(8'h41, "R8 vector line 1");
        chk("R7 lower blocked", int_out, 0);
        wr(0, 8'h0B);
        peek_ctl(8'h0A, "R10 isr readback");
        wr(0, 8'h00);
        peek_ctl(8'h0A, "R9 other cmd ignored");
        wr(0, 8'h20);
        peek_ctl(8'h08, "R9 eoi clears line 1");
        wr(0, 8'h20);
        peek_ctl(8'h00, "R9 eoi clears line 3");
        chk("R7 line 5 now", int_out, 1);
        ack(8'h45, "R8 vector line 5");
        wr(0, 8'h20);
        irq_in = 0;
        cyc();

        // R4 masking
        wr(1, 8'h04);
        irq_in = 8'h04;
        cyc(); cyc();
        chk("R4 masked line", int_out, 0);
        wr(1, 8'h00);
        chk("R4 unmasked line", int_out, 1);
        ack(8'h42, "R8 vector line 2");
        wr(0, 8'h20);
        irq_in = 0;
        cyc();

        // R6 level mode via trigger register
        trig_we = 1; wr_data = 8'h80;
        cyc();
        trig_we = 0;
        irq_in = 8'h80;
        #1 chk("R6 level immediate", int_out, 1);
        ack(8'h47, "R8 vector line 7");
        wr(0, 8'h20);
        chk("R6 level re-requests", int_out, 1);
        irq_in = 0;
        #1 chk("R6 level drops", int_out, 0);
        cyc();

        // R11 acknowledge with nothing pending
        ack(8'h47, "R11 spurious vector");
        peek_ctl(8'h00, "R11 isr unchanged");
        cyc();

        // R2/R10 reconfiguration: global level, no mode word
        irq_in = 8'h80;
        wr(0, 8'h18);
        peek_ctl(8'h80, "R10 start selects irr");
        wr(1, 8'h80);
        wr(1, 8'h02);
        chk("R3 slave identity", cascade_cfg, 8'h02);
        wr(1, 8'h55);
        addr = 1; #1 chk("R2 mask after short sequence", rd_data, 8'h55);
        addr = 0;
        irq_in = 8'h42;
        #1 chk("R6 global level", int_out, 1);
        ack(8'h81, "R3 new base");
        wr(0, 8'h20);
        irq_in = 0;
        repeat (3) cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule